// File: doc/BRIEF.md
# Dual Interrupt Output Router

This block takes two alarm sources that are generated elsewhere, a time-of-day match and a watchdog expiry, and places them on two open-drain interrupt pins. One select bit decides which alarm goes to pin A. Pin B always carries the other alarm, so the two pins never show the same source and neither source is ever dropped.

Pin A is active low. It can follow its alarm as a level, or it can give a fixed-width pulse on each rising edge of that alarm. The active sense of pin B can be set high or low. The block never drives a pin high. Each output is a pull-low enable for an external driver, and an external resistor pulls the pin up. The block has no link to the main supply, so it keeps working on the backup supply in the same way as on the main supply.

Top module: `irq_router`

## Requirements
- R1: After reset, pin_a_pull is 0. The pulse counter is clear, and pin_b_pull equals b_active_high.
- R2: When swap_sel is 0, pin A takes tod_alarm and pin B takes wdog_alarm. When swap_sel is 1, pin A takes wdog_alarm and pin B takes tod_alarm.
- R3: In level mode (a_pulse_mode = 0), pin_a_pull equals the value that pin A's alarm had at the previous clock edge. The pull is active while the alarm is high, which pulls the pin low.
- R4: In pulse mode (a_pulse_mode = 1), suppose pin A's alarm is high at a clock edge and was low at the edge before. Then pin_a_pull is 1 for exactly PULSE_CYCLES cycles (default 8), starting after that edge, and then returns to 0.
- R5: A rising edge of the alarm that arrives while a pulse is running neither extends the pulse nor restarts it.
- R6: pin_b_pull equals B's alarm value from the previous edge when b_active_high is 0. It equals the inverse of that value when b_active_high is 1, so the pin rises while the alarm is active.
- R7: A change of swap_sel is taken at the next clock edge. That edge clears any running pulse and starts no new one.
- R8: A change of a_pulse_mode or b_active_high changes the pin outputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, running from the backup-capable domain |
| rst_n | input | 1 | Asynchronous reset, active low |
| tod_alarm | input | 1 | Time-of-day alarm level |
| wdog_alarm | input | 1 | Watchdog alarm level |
| swap_sel | input | 1 | 0: A = time-of-day, B = watchdog; 1: reversed |
| a_pulse_mode | input | 1 | 0: pin A as level, 1: pin A as pulse |
| b_active_high | input | 1 | 1: pin B rises while its alarm is active |
| pin_a_pull | output | 1 | Pull-low enable for pin A |
| pin_b_pull | output | 1 | Pull-low enable for pin B |

## Verification
Suppose the stored select copy or the edge-history bit is wrong. A pulse then starts when no edge occurred, or is missing after a real edge. This shows on pin_a_pull one cycle after the faulty edge. A wrong counter value makes the pulse too long or too short, and this shows when the pulse ends, at most PULSE_CYCLES cycles later. A wrong stored B level shows on pin_b_pull in the next cycle, with either polarity.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tod_alarm,
  input  logic wdog_alarm,
  input  logic swap_sel,
  input  logic a_pulse_mode,
  input  logic b_active_high,
  output logic pin_a_pull,
  output logic pin_b_pull
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic          a_src, b_src;
  logic          sel_q, a_prev, a_lvl, b_lvl;
  logic [CW-1:0] pulse_cnt;

  assign a_src = swap_sel ? wdog_alarm : tod_alarm;
  assign b_src = swap_sel ? tod_alarm  : wdog_alarm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= 1'b0;
      a_prev    <= 1'b0;
      a_lvl     <= 1'b0;
      b_lvl     <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      sel_q  <= swap_sel;
      a_prev <= a_src;
      a_lvl  <= a_src;
      b_lvl  <= b_src;
      if (swap_sel != sel_q)
        pulse_cnt <= '0;
      else if (pulse_cnt != '0)
        pulse_cnt <= pulse_cnt - 1'b1;
      else if (a_src && !a_prev)
        pulse_cnt <= LOAD;
    end
  end

  assign pin_a_pull = a_pulse_mode ? (pulse_cnt != '0) : a_lvl;
  assign pin_b_pull = b_active_high ? ~b_lvl : b_lvl;
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int PULSE_CYCLES = 8,
  parameter int CW = $clog2(PULSE_CYCLES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tod_alarm,
  input logic          wdog_alarm,
  input logic          swap_sel,
  input logic          a_pulse_mode,
  input logic          b_active_high,
  input logic          pin_a_pull,
  input logic          pin_b_pull,
  input logic          sel_q,
  input logic [CW-1:0] pulse_cnt
);
  logic a_src_c, b_src_c;
  assign a_src_c = swap_sel ? wdog_alarm : tod_alarm;
  assign b_src_c = swap_sel ? tod_alarm  : wdog_alarm;

  a_r7_sel_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_sel != sel_q) |=> (pulse_cnt == '0));

  a_r5_no_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt != '0 && swap_sel == sel_q) |=> (pulse_cnt == $past(pulse_cnt) - 1'b1));

  a_r4_cnt_max: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt <= CW'(PULSE_CYCLES)));

  a_r6_b_active: assert property (@(posedge clk) disable iff (!rst_n)
    b_src_c |=> (pin_b_pull == !b_active_high));

  a_r6_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !b_src_c |=> (pin_b_pull == b_active_high));

  a_r3_level_on: assert property (@(posedge clk) disable iff (!rst_n)
    a_src_c |=> (a_pulse_mode || pin_a_pull));

  a_r3_level_off: assert property (@(posedge clk) disable iff (!rst_n)
    !a_src_c |=> (a_pulse_mode || !pin_a_pull));
endmodule

bind irq_router irq_router_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tod_alarm(tod_alarm), .wdog_alarm(wdog_alarm),
  .swap_sel(swap_sel), .a_pulse_mode(a_pulse_mode), .b_active_high(b_active_high),
  .pin_a_pull(pin_a_pull), .pin_b_pull(pin_b_pull),
  .sel_q(sel_q), .pulse_cnt(pulse_cnt)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tod = 1'b0, wdog = 1'b0, sel = 1'b0, pmode = 1'b0, bpol = 1'b0;
  logic pin_a, pin_b;
  int checks = 0, errors = 0;

  logic m_selq, m_prev, m_lvl, m_b;
  int   m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_router #(.PULSE_CYCLES(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tod_alarm(tod), .wdog_alarm(wdog),
    .swap_sel(sel), .a_pulse_mode(pmode), .b_active_high(bpol),
    .pin_a_pull(pin_a), .pin_b_pull(pin_b));

  function automatic logic src_a_f(logic s, logic t, logic w);
    return s ? w : t;
  endfunction
  function automatic logic src_b_f(logic s, logic t, logic w);
    return s ? t : w;
  endfunction
  function automatic logic exp_a();
    return pmode ? (m_cnt != 0) : m_lvl;
  endfunction
  function automatic logic exp_b();
    return bpol ? !m_b : m_b;
  endfunction

  task automatic check(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_selq = 0; m_prev = 0; m_lvl = 0; m_b = 0; m_cnt = 0;
  endtask

  task automatic step();
    logic a;
    @(posedge clk);
    #1;
    a = src_a_f(sel, tod, wdog);
    if (sel != m_selq) m_cnt = 0;
    else if (m_cnt != 0) m_cnt--;
    else if (a && !m_prev) m_cnt = PULSE;
    m_prev = a; m_selq = sel; m_lvl = a; m_b = src_b_f(sel, tod, wdog);
    #1;
    check(pmode ? "R4" : "R3", pin_a, exp_a());
    check("R6", pin_b, exp_b());
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    int width;
    void'($urandom(32'h1234_5678));
    model_reset();
    bpol = 1'b1;
    #(CLK_PERIOD * 3);
    check("R1", pin_a, 1'b0);
    check("R1", pin_b, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    step();

    // R2: routing in both select settings, level mode
    wdog = 1'b1; step(); step();
    check("R2", pin_a, 1'b0);
    check("R2", pin_b, 1'b0);
    sel = 1'b1; step(); step();
    check("R2", pin_a, 1'b1);
    check("R2", pin_b, 1'b1);
    wdog = 1'b0; sel = 1'b0; step(); step();

    // R4: pulse width
    pmode = 1'b1; bpol = 1'b0;
    tod = 1'b1; width = 0;
    for (int i = 0; i < PULSE + 4; i++) begin step(); if (pin_a) width++; end
    check("R4", width == PULSE, 1'b1);
    tod = 1'b0; step();

    // R5: retrigger during pulse does not extend
    tod = 1'b1; width = 0;
    for (int i = 0; i < PULSE + 6; i++) begin
      if (i == 3) tod = 1'b0;
      if (i == 4) tod = 1'b1;
      step(); if (pin_a) width++;
    end
    check("R5", width == PULSE, 1'b1);
    tod = 1'b0; step();

    // R7: select change cancels pulse
    tod = 1'b1; step(); step(); step();
    check("R7", pin_a, 1'b1);
    sel = 1'b1; step();
    check("R7", pin_a, 1'b0);
    step();
    check("R7", pin_a, 1'b0);
    tod = 1'b0; sel = 1'b0; step(); step();

    // R8: configuration bits act without a clock edge
    wdog = 1'b1; step();
    #1 bpol = ~bpol; #1;
    check("R8", pin_b, exp_b());
    tod = 1'b1; pmode = 1'b0; step();
    #1 pmode = 1'b1; #1;
    check("R8", pin_a, exp_a());
    #1 pmode = 1'b0; #1;
    check("R8", pin_a, exp_a());

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) tod = ~tod;
      if ($urandom_range(0, 5) == 0) wdog = ~wdog;
      if ($urandom_range(0, 40) == 0) sel = ~sel;
      if ($urandom_range(0, 60) == 0) pmode = ~pmode;
      if ($urandom_range(0, 60) == 0) bpol = ~bpol;
      step();
    end
    finish_up();
  end
endmodule